// File: doc/BRIEF.md
# Message-Signalled Interrupt Termination Unit

The unit takes message-signalled interrupt writes from a simple memory-mapped write port. It records each one as a pending bit in a grid of 128 termination registers, arranged as 16 groups of 8 index registers with 16 vectors each, for 2048 vectors in all. The written data value picks which bit of the addressed register is set. No data word is stored.

Software collects interrupts through a read port. Reading a termination register returns its pending vectors and clears them in the same access. Each group also has a summary word that can be read with no side effect. The summary has one bit per index register and shows which of them hold pending vectors. Each group drives one level-sensitive interrupt line, which stays high while anything in that group is pending.

Top module: `msi_term_unit`

## Requirements
- R1: A write strobe whose address has bit 23 = 0 and bits 15:0 = 0, and whose data value v is 0..15, sets pending bit v of termination register (group = addr[22:19], index = addr[18:16]). The bit is visible from the cycle after the strobe. Every other pending bit keeps its value.
- R2: A read strobe to a termination register address returns that register's 16 pending bits in rd_data[15:0], with the upper bits zero. rd_valid is high in the cycle after the strobe. The register is empty from then on.
- R3: A read of summary address 0x800000 + (g << 16) returns in bit x (x = 0..7) whether index register x of group g holds any pending bit. Such a read changes no state.
- R4: irq_o[g] is high in every cycle in which some termination register of group g holds a pending bit, and low otherwise.
- R5: When a write and a read-to-clear hit the same termination register in the same cycle, the read returns the old contents. The newly written bit stays pending afterwards.
- R6: A write with a data value above 15 changes no pending bit.
- R7: Writes to the summary region, or to an undecoded address, change no pending bit. An undecoded address has nonzero bits 15:0, or has bit 23 set together with any of bits 22:20 set.
- R8: A read of an undecoded address returns zero with rd_valid high, and clears nothing.
- R9: While rst_n is low, all pending bits are cleared, irq_o is all zero and rd_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 24 | Write offset from the block base |
| wr_data | input | 32 | Write data; its value selects the vector |
| rd_en | input | 1 | One-cycle read strobe |
| rd_addr | input | 24 | Read offset from the block base |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | High in the cycle after a read strobe |
| irq_o | output | 16 | One level interrupt per group |

## Verification
Every result is due exactly one cycle after its strobe edge:
- A pending bit set by a write shows on the group's interrupt line right after that edge.
- Read data appears with rd_valid after the edge that sampled the read.
- The clear caused by a read shows on the interrupt lines after that same edge.

Each operation is driven on a falling edge. The bench model records the expected read word when the strobe is issued and queues it. A monitor compares the word on the next falling edge on which rd_valid is high. Interrupt lines are compared against the model on the falling edge after each operation, so every comparison falls half a cycle after the edge that produced the value.

// File: rtl/msi_term_pkg.sv
package msi_term_pkg;
  localparam int NUM_GRP     = 16;
  localparam int IDX_PER_GRP = 8;
  localparam int VEC_PER_IDX = 16;
  localparam int GRP_W       = $clog2(NUM_GRP);
  localparam int IDX_W       = $clog2(IDX_PER_GRP);
  localparam int VEC_W       = $clog2(VEC_PER_IDX);
  localparam int NUM_REG     = NUM_GRP * IDX_PER_GRP;
  localparam int REG_W       = $clog2(NUM_REG);
  localparam int NUM_VEC     = NUM_REG * VEC_PER_IDX;
  localparam int WIN_LSB     = 16;  // each register owns a 64 KiB window

  typedef struct packed {
    logic             idx_hit;
    logic             sum_hit;
    logic [GRP_W-1:0] grp;
    logic [IDX_W-1:0] idx;
  } msi_dec_t;
endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode
  import msi_term_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr,
  output msi_dec_t          dec
);
  // termination space: [MSB]=0, group above index above the window offset
  localparam int IDX_LSB = WIN_LSB;
  localparam int GRP_LSB = WIN_LSB + IDX_W;
  // summary space: [MSB]=1, group directly above the window offset
  localparam int PAD_LSB = WIN_LSB + GRP_W;
  localparam int PAD_MSB = ADDR_W - 2;

  logic win_zero;
  logic top_bit;
  logic pad_zero;

  always_comb begin
    win_zero = (addr[WIN_LSB-1:0] == '0);
    top_bit  = addr[ADDR_W-1];
    pad_zero = (addr[PAD_MSB:PAD_LSB] == '0);
    dec.idx_hit = win_zero && !top_bit;
    dec.sum_hit = win_zero && top_bit && pad_zero;
    if (top_bit) begin
      dec.grp = addr[WIN_LSB +: GRP_W];
      dec.idx = '0;
    end else begin
      dec.grp = addr[GRP_LSB +: GRP_W];
      dec.idx = addr[IDX_LSB +: IDX_W];
    end
  end
endmodule

// File: rtl/msi_index_reg.sv
module msi_index_reg
  import msi_term_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   set_en,
  input  logic [VEC_W-1:0]       set_sel,
  input  logic                   clr_en,
  output logic [VEC_PER_IDX-1:0] pend_o
);
  logic [VEC_PER_IDX-1:0] pend_q;
  logic [VEC_PER_IDX-1:0] pend_d;
  logic                   pend_ce;

  always_comb begin
    pend_ce = set_en | clr_en;
    pend_d  = pend_q;
    if (clr_en) pend_d = '0;
    if (set_en) pend_d[set_sel] = 1'b1;  // set wins over same-cycle clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_ce) pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/msi_group_summary.sv
module msi_group_summary
  import msi_term_pkg::*;
(
  input  logic [NUM_VEC-1:0] pend_flat,
  output logic [NUM_REG-1:0] sum_flat,
  output logic [NUM_GRP-1:0] irq
);
  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    assign sum_flat[r] = |pend_flat[r*VEC_PER_IDX +: VEC_PER_IDX];
  end
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign irq[g] = |sum_flat[g*IDX_PER_GRP +: IDX_PER_GRP];
  end
endmodule

// File: rtl/msi_term_unit.sv
module msi_term_unit
  import msi_term_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [NUM_GRP-1:0] irq_o
);
  msi_dec_t           wdec;
  msi_dec_t           rdec;
  logic [REG_W-1:0]   wreg;
  logic [REG_W-1:0]   rreg;
  logic               wr_ok;
  logic               rd_clr;
  logic [NUM_VEC-1:0] pend_flat;
  logic [NUM_REG-1:0] sum_flat;
  logic [DATA_W-1:0]  rd_word;
  logic [DATA_W-1:0]  rd_data_q;
  logic               rd_valid_q;

  msi_addr_decode #(.ADDR_W(ADDR_W)) u_wdec (.addr(wr_addr), .dec(wdec));
  msi_addr_decode #(.ADDR_W(ADDR_W)) u_rdec (.addr(rd_addr), .dec(rdec));

  always_comb begin
    wreg   = {wdec.grp, wdec.idx};
    rreg   = {rdec.grp, rdec.idx};
    wr_ok  = wr_en && wdec.idx_hit && (wr_data[DATA_W-1:VEC_W] == '0);
    rd_clr = rd_en && rdec.idx_hit;
  end

  for (genvar r = 0; r < NUM_REG; r++) begin : g_term
    msi_index_reg u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (wr_ok && (wreg == REG_W'(r))),
      .set_sel(wr_data[VEC_W-1:0]),
      .clr_en (rd_clr && (rreg == REG_W'(r))),
      .pend_o (pend_flat[r*VEC_PER_IDX +: VEC_PER_IDX])
    );
  end

  msi_group_summary u_sum (
    .pend_flat(pend_flat),
    .sum_flat (sum_flat),
    .irq      (irq_o)
  );

  always_comb begin
    rd_word = '0;
    if (rdec.idx_hit)
      rd_word[VEC_PER_IDX-1:0] = pend_flat[rreg*VEC_PER_IDX +: VEC_PER_IDX];
    else if (rdec.sum_hit)
      rd_word[IDX_PER_GRP-1:0] = sum_flat[rdec.grp*IDX_PER_GRP +: IDX_PER_GRP];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) rd_data_q <= rd_word;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
endmodule

// File: rtl/msi_term_unit_chk.sv
module msi_term_unit_chk
  import msi_term_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [DATA_W-1:0]  wr_data,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic [DATA_W-1:0]  rd_data,
  input logic               rd_valid,
  input logic [NUM_GRP-1:0] irq_o,
  input logic [NUM_VEC-1:0] pend_flat
);
  logic        w_hit;
  logic        r_hit;
  logic        r_undec;
  logic [31:0] w_bit;
  logic [31:0] r_base;

  always_comb begin
    w_hit   = wr_en && !wr_addr[ADDR_W-1] && (wr_addr[WIN_LSB-1:0] == '0)
              && (wr_data < VEC_PER_IDX);
    r_hit   = rd_en && !rd_addr[ADDR_W-1] && (rd_addr[WIN_LSB-1:0] == '0);
    r_undec = rd_en && ((rd_addr[WIN_LSB-1:0] != '0) ||
              (rd_addr[ADDR_W-1] && (rd_addr[ADDR_W-2:WIN_LSB+GRP_W] != '0)));
    w_bit   = 32'(wr_addr[ADDR_W-2:WIN_LSB]) * VEC_PER_IDX + 32'(wr_data[VEC_W-1:0]);
    r_base  = 32'(rd_addr[ADDR_W-2:WIN_LSB]) * VEC_PER_IDX;
  end

  // R1
  wr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_hit |=> pend_flat[$past(w_bit)]);

  // R2
  rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_hit && !(w_hit && wr_addr == rd_addr)) |=> (pend_flat[$past(r_base) +: VEC_PER_IDX] == '0));

  // R2
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // R8
  undec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_undec |=> (rd_data == '0));

  // R4
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_flat == '0) |-> (irq_o == '0));
endmodule

bind msi_term_unit msi_term_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
  .irq_o(irq_o), .pend_flat(pend_flat)
);

// File: tb/msi_term_unit_tb.sv
module msi_term_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [23:0] wr_addr;
  logic [31:0] wr_data;
  logic        rd_en;
  logic [23:0] rd_addr;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [15:0] irq_o;

  int checks;
  int errors;
  logic [15:0] model [128];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  msi_term_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [23:0] ia(int g, int x);
    return {1'b0, 4'(g), 3'(x), 16'h0000};
  endfunction

  function automatic logic [23:0] sa(int g);
    return 24'h800000 | (24'(g) << 16);
  endfunction

  function automatic logic [15:0] model_irq();
    logic [15:0] v = '0;
    for (int r = 0; r < 128; r++) if (model[r] != 0) v[r/8] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] model_read(logic [23:0] a);
    logic [31:0] v = '0;
    if (a[15:0] != 0) return '0;
    if (!a[23]) return {16'h0, model[a[22:16]]};
    if (a[22:20] != 0) return '0;
    for (int x = 0; x < 8; x++) v[x] = (model[a[19:16]*8 + x] != 0);
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: one cycle with optional write and read; expected read word queued
  task automatic op(bit dw, logic [23:0] wa, logic [31:0] wd,
                    bit dr, logic [23:0] ra, string tag);
    @(negedge clk);
    wr_en = dw; wr_addr = wa; wr_data = wd;
    rd_en = dr; rd_addr = ra;
    if (dr) begin
      exp_q.push_back(model_read(ra));
      tag_q.push_back(tag);
      if (ra[15:0] == 0 && !ra[23]) model[ra[22:16]] = '0;
    end
    if (dw && wa[15:0] == 0 && !wa[23] && wd < 16) model[wa[22:16]][wd[3:0]] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic irq_chk(string req);
    check(req, {16'h0, irq_o}, {16'h0, model_irq()});
  endtask

  // monitor: pops expected read words as results appear
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: actual rd_valid=1 expected no read pending");
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < WATCHDOG) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    wr_en = 0; rd_en = 0; wr_addr = '0; rd_addr = '0; wr_data = '0;
    for (int r = 0; r < 128; r++) model[r] = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 irq", {16'h0, irq_o}, 32'h0);
    check("R9 rd_valid", {31'h0, rd_valid}, 32'h0);
    rst_n = 1'b1;
    op(0, 0, 0, 1, sa(0), "R9 summary after reset");

    // R1 / R4: two vectors into group 3 index 5
    op(1, ia(3, 5), 7, 0, 0, "");
    irq_chk("R4 after first write");
    op(1, ia(3, 5), 0, 0, 0, "");
    irq_chk("R4 after second write");
    op(0, 0, 0, 1, sa(3), "R3 summary g3");
    op(0, 0, 0, 1, sa(3), "R3 summary no side effect");
    op(0, 0, 0, 1, ia(3, 5), "R1 R2 read pending word");
    irq_chk("R4 clear drops irq");
    op(0, 0, 0, 1, ia(3, 5), "R2 empty after read");

    // R6: out-of-range data
    op(1, ia(1, 0), 16, 0, 0, "");
    op(1, ia(1, 0), 32'h8000_0003, 0, 0, "");
    irq_chk("R6 irq unchanged");
    op(0, 0, 0, 1, ia(1, 0), "R6 no bit set");

    // R7: summary region and undecoded writes
    op(1, sa(1), 2, 0, 0, "");
    op(1, 24'h000004, 1, 0, 0, "");
    op(1, 24'h900000, 1, 0, 0, "");
    irq_chk("R7 irq unchanged");
    op(0, 0, 0, 1, ia(0, 0), "R7 no bit set");

    // R8: undecoded read returns zero and clears nothing
    op(1, ia(0, 0), 1, 0, 0, "");
    op(0, 0, 0, 1, 24'h000010, "R8 low offset");
    op(0, 0, 0, 1, 24'hA00000, "R8 high pad");
    op(0, 0, 0, 1, ia(0, 0), "R8 bit kept");

    // R5: write and read-to-clear of one register in one cycle
    op(1, ia(15, 7), 15, 0, 0, "");
    op(1, ia(15, 7), 3, 1, ia(15, 7), "R5 old value returned");
    irq_chk("R5 irq stays");
    op(0, 0, 0, 1, ia(15, 7), "R5 new bit kept");

    // several groups at once, write and read of different registers together
    op(1, ia(2, 0), 1, 0, 0, "");
    op(1, ia(9, 3), 12, 0, 0, "");
    op(1, ia(9, 6), 4, 1, ia(2, 0), "R2 independent read");
    irq_chk("R4 multi group");
    op(0, 0, 0, 1, sa(9), "R3 summary g9");

    // R9: reset mid-run
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    for (int r = 0; r < 128; r++) model[r] = '0;
    @(negedge clk);
    check("R9 irq cleared", {16'h0, irq_o}, 32'h0);
    check("R9 rd_valid low", {31'h0, rd_valid}, 32'h0);
    rst_n = 1'b1;
    op(0, 0, 0, 1, ia(9, 3), "R9 pending cleared");
    repeat (3) @(negedge clk);
    check("R2 all reads returned", 32'(exp_q.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule